// File: doc/BRIEF.md
# Reference Clock Watchdog with Duty-Cycle Check

This block watches an external reference clock, nominally 250 kHz, and samples it with a faster internal clock that always runs. It measures every period of the reference in sample ticks, from one rising edge to the next. It counts how many samples in that period were high and how many were low. It raises a single failure flag when the reference stops toggling or runs too slowly. It also raises the flag when the high share of a period falls outside a fixed band around half.

Downstream logic uses the flag to switch every power enable off and to drive every channel status into its error state. The flag comes out of reset set. It drops only after the reference has delivered a run of consecutive valid periods. One marginal period is therefore not enough to clear it.

Top module: `refwd_top`

## Requirements
- R1: `fail_o` is 1 during reset and after reset. It stays 1 while the reference shows no valid periods.
- R2: A period is the span from one synchronized rising edge of `mon_clk_i` to the next. Within it, H counts the high samples and L counts the low samples. Every completed period receives exactly one verdict.
- R3: A period is good when DUTY_MIN_PCT·(H+L) ≤ 100·H ≤ DUTY_MAX_PCT·(H+L), bounds included. The defaults are 45 and 55.
- R4: A period whose high share is below DUTY_MIN_PCT sets `fail_o` within 4 sample cycles of the rising edge that ends it.
- R5: A period whose high share is above DUTY_MAX_PCT sets `fail_o` in the same way.
- R6: If no rising edge is seen for MAX_PERIOD_TICKS sample cycles, `fail_o` is set. This covers a reference stuck low and a reference stuck high.
- R7: Once set, `fail_o` clears only after GOOD_PERIODS consecutive good periods (default 2). A single good period after a failure leaves it set.
- R8: While `fail_o` is 0, an unbroken stream of good periods keeps it 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal sampling clock, free running |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| mon_clk_i | input | 1 | Monitored reference clock, asynchronous |
| fail_o | output | 1 | Clock failure flag, 1 = reference absent or invalid |

## Verification
The bench builds the block with MAX_PERIOD_TICKS = 64 and the default 45/55 band and two-period recovery. With this small period limit, every high/low split from 1 to 24 ticks per phase can be swept, 576 combinations in all. Both duty boundaries fall on exact tick counts, for example 9/20 and 11/20, so the inclusive bounds are checked directly. The same short limit lets the stuck-low and stuck-high timeouts, the one-good-period hold and single bad periods inside a good stream each be observed within a few hundred cycles.

// File: rtl/refwd_pkg.sv
package refwd_pkg;

    // Verdict passed from the duty judge to the failure latch.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_GOOD = 2'd1,
        EV_BAD  = 2'd2
    } ev_kind_e;

    // Scale used for the percentage comparison.
    localparam int unsigned PCT_SCALE = 100;

endpackage

// File: rtl/refwd_sync.sv
module refwd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = async_i;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/refwd_phase.sv
module refwd_phase #(
    parameter int unsigned MAX_TICKS = 500,
    parameter int unsigned CW        = 9
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          lvl_i,
    output logic          per_end_o,
    output logic [CW-1:0] hi_o,
    output logic [CW-1:0] lo_o,
    output logic          stall_o
);
    localparam logic [CW-1:0] CAP = CW'(MAX_TICKS);

    typedef struct packed {
        logic          prev;
        logic          started;
        logic [CW-1:0] hi;
        logic [CW-1:0] lo;
        logic [CW-1:0] run;
    } st_t;

    st_t s_d, s_q;
    logic rise;

    always_comb begin
        s_d      = s_q;
        s_d.prev = lvl_i;
        rise     = lvl_i && !s_q.prev;
        if (rise) begin
            s_d.started = 1'b1;
            s_d.hi      = CW'(1);
            s_d.lo      = '0;
            s_d.run     = CW'(1);
        end else begin
            if (lvl_i) s_d.hi = (s_q.hi == CAP) ? CAP : s_q.hi + 1'b1;
            else       s_d.lo = (s_q.lo == CAP) ? CAP : s_q.lo + 1'b1;
            s_d.run = (s_q.run == CAP) ? CAP : s_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign per_end_o = rise && s_q.started;
    assign hi_o      = s_q.hi;
    assign lo_o      = s_q.lo;
    assign stall_o   = (s_q.run == CAP);

    // R2
    period_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        per_end_o |-> (hi_o != '0) && (lo_o != '0));

    // R6
    stall_no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stall_o) |-> $stable(s_q.prev));
endmodule

// File: rtl/refwd_judge.sv
module refwd_judge
    import refwd_pkg::*;
#(
    parameter int unsigned CW      = 9,
    parameter int unsigned MIN_PCT = 45,
    parameter int unsigned MAX_PCT = 55
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          per_end_i,
    input  logic [CW-1:0] hi_i,
    input  logic [CW-1:0] lo_i,
    output ev_kind_e      ev_o
);
    localparam int unsigned PW = CW + 8;

    typedef struct packed {
        ev_kind_e ev;
    } st_t;

    st_t s_d, s_q;
    logic [PW-1:0] tot, lhs, lim_lo, lim_hi;
    logic          in_band;

    always_comb begin
        tot     = PW'(hi_i) + PW'(lo_i);
        lhs     = PW'(hi_i) * PW'(PCT_SCALE);
        lim_lo  = tot * PW'(MIN_PCT);
        lim_hi  = tot * PW'(MAX_PCT);
        in_band = (lhs >= lim_lo) && (lhs <= lim_hi);
        s_d.ev  = EV_NONE;
        if (per_end_i) s_d.ev = in_band ? EV_GOOD : EV_BAD;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '{ev: EV_NONE};
        else         s_q <= s_d;
    end

    assign ev_o = s_q.ev;

    // R2
    verdict_per_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        per_end_i |=> (ev_o != EV_NONE));

    // R2
    no_spurious_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !per_end_i |=> (ev_o == EV_NONE));
endmodule

// File: rtl/refwd_latch.sv
module refwd_latch
    import refwd_pkg::*;
#(
    parameter int unsigned GOOD_PERIODS = 2
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  ev_kind_e ev_i,
    input  logic     stall_i,
    output logic     fail_o
);
    localparam int unsigned GW = $clog2(GOOD_PERIODS + 1);

    typedef struct packed {
        logic          fail;
        logic [GW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (stall_i) begin
            s_d.fail = 1'b1;
            s_d.cnt  = '0;
        end else if (ev_i == EV_BAD) begin
            s_d.fail = 1'b1;
            s_d.cnt  = '0;
        end else if (ev_i == EV_GOOD && s_q.fail) begin
            if (32'(s_q.cnt) + 1 >= GOOD_PERIODS) begin
                s_d.fail = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '{fail: 1'b1, cnt: '0};
        else         s_q <= s_d;
    end

    assign fail_o = s_q.fail;

    // R6
    stall_sets_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_i |=> fail_o);

    // R4
    bad_sets_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_i == EV_BAD) |=> fail_o);

    // R7
    clear_after_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(fail_o) |-> $past(ev_i == EV_GOOD));

    // R8
    good_keeps_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fail_o && ev_i != EV_BAD && !stall_i) |=> !fail_o);
endmodule

// File: rtl/refwd_top.sv
module refwd_top
    import refwd_pkg::*;
#(
    parameter int unsigned MAX_PERIOD_TICKS = 500,
    parameter int unsigned DUTY_MIN_PCT     = 45,
    parameter int unsigned DUTY_MAX_PCT     = 55,
    parameter int unsigned GOOD_PERIODS     = 2,
    parameter int unsigned SYNC_STAGES      = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mon_clk_i,
    output logic fail_o
);
    localparam int unsigned CW = $clog2(MAX_PERIOD_TICKS + 1);

    logic          lvl;
    logic          per_end;
    logic [CW-1:0] hi_cnt, lo_cnt;
    logic          stall;
    ev_kind_e      ev;

    refwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(mon_clk_i),
        .sync_o (lvl)
    );

    refwd_phase #(.MAX_TICKS(MAX_PERIOD_TICKS), .CW(CW)) u_phase (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lvl_i    (lvl),
        .per_end_o(per_end),
        .hi_o     (hi_cnt),
        .lo_o     (lo_cnt),
        .stall_o  (stall)
    );

    refwd_judge #(.CW(CW), .MIN_PCT(DUTY_MIN_PCT), .MAX_PCT(DUTY_MAX_PCT)) u_judge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .per_end_i(per_end),
        .hi_i     (hi_cnt),
        .lo_i     (lo_cnt),
        .ev_o     (ev)
    );

    refwd_latch #(.GOOD_PERIODS(GOOD_PERIODS)) u_latch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ev_i   (ev),
        .stall_i(stall),
        .fail_o (fail_o)
    );
endmodule

// File: tb/tb_refwd_top.sv
module tb_refwd_top;
    localparam int MAXP = 64;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic mon = 1'b0;
    logic fail;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    refwd_top #(.MAX_PERIOD_TICKS(MAXP)) dut (
        .clk_i    (clk),
        .rst_ni   (rst_ni),
        .mon_clk_i(mon),
        .fail_o   (fail)
    );

    task automatic report_end();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: fail_o=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic hold(input logic lv, input int n);
        mon = lv;
        repeat (n) @(negedge clk);
    endtask

    task automatic period(input int h, input int l);
        hold(1'b1, h);
        hold(1'b0, l);
    endtask

    function automatic logic exp_fail(input int h, input int l);
        return !((100 * h >= 45 * (h + l)) && (100 * h <= 55 * (h + l)));
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual running expected done");
            report_end();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(fail, 1'b1, "R1 during reset");
        rst_ni = 1'b1;
        hold(1'b0, 20);
        chk(fail, 1'b1, "R1 after reset, no clock");

        // R2 R3 R4 R5: sweep every high/low split
        for (int h = 1; h <= 24; h++) begin
            for (int l = 1; l <= 24; l++) begin
                for (int k = 0; k < 6; k++) period(h, l);
                chk(fail, exp_fail(h, l),
                    $sformatf("R3 split H=%0d L=%0d", h, l));
            end
        end

        // R8: good stream keeps flag clear
        for (int k = 0; k < 5; k++) period(10, 10);
        chk(fail, 1'b0, "R8 good stream");

        // R6: stuck low, not before limit, then after
        hold(1'b0, 30);
        chk(fail, 1'b0, "R6 stuck low below limit");
        hold(1'b0, 30);
        chk(fail, 1'b1, "R6 stuck low past limit");

        for (int k = 0; k < 5; k++) period(10, 10);
        chk(fail, 1'b0, "R7 recovered after stuck low");
        hold(1'b1, 80);
        chk(fail, 1'b1, "R6 stuck high");

        // R7: one good period is not enough
        hold(1'b0, 10);
        period(10, 10);
        period(10, 10);
        chk(fail, 1'b1, "R7 single good period");
        period(10, 10);
        chk(fail, 1'b0, "R7 two good periods");

        // R4: single low-duty period in a good stream
        period(5, 15);
        period(10, 10);
        chk(fail, 1'b1, "R4 low duty sets flag");
        period(10, 10);
        chk(fail, 1'b1, "R7 hold after low duty");
        period(10, 10);
        chk(fail, 1'b0, "R7 clear after low duty");

        // R5: single high-duty period in a good stream
        period(15, 5);
        period(10, 10);
        chk(fail, 1'b1, "R5 high duty sets flag");
        period(10, 10);
        period(10, 10);
        chk(fail, 1'b0, "R7 clear after high duty");

        // R3: exact boundaries 45 % and 55 % accepted, just outside rejected
        for (int k = 0; k < 5; k++) period(9, 11);
        chk(fail, 1'b0, "R3 45 percent inclusive");
        for (int k = 0; k < 5; k++) period(11, 9);
        chk(fail, 1'b0, "R3 55 percent inclusive");
        for (int k = 0; k < 5; k++) period(4, 5);
        chk(fail, 1'b1, "R4 44 percent rejected");
        for (int k = 0; k < 5; k++) period(5, 4);
        chk(fail, 1'b1, "R5 56 percent rejected");

        if (!done) begin
            done = 1'b1;
            report_end();
        end
    end
endmodule